// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control half of an on-chip analog-to-digital converter. It holds an 8-bit control and status word on a simple write/read port. It derives a converter clock from the system clock through a selectable power-of-two prescaler. It counts converter-clock periods to decide when a conversion is finished. When one finishes, it latches the result word presented on an input port and sets a completion flag. It raises an interrupt request while that flag and the interrupt enable are both set.

Conversions are started in three ways. In single-shot mode software writes the start bit. In auto-triggered mode a rising edge on the trigger input starts a conversion. In free-running mode, software starts the first conversion and every later one begins as the previous one ends. The first conversion after the converter is enabled is longer, because it covers the analog initialisation. The analog sampling and comparison are not part of this block: the result arrives as a plain input word.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00, the interrupt request is low and the result output is 0.
- R2: The control word bit layout, from bit 7 down to bit 0, is: enable, start/busy, auto-trigger enable, completion flag, interrupt enable, and a 3-bit prescaler code in bits 2:0. The enable, auto-trigger, interrupt-enable and prescaler fields read back as written.
- R3: The converter clock period is 2^k system cycles. Prescaler code 0 gives k=1. Any other code c gives k=c, so codes 0 and 1 both divide by 2, and codes 2, 3, 5 and 7 divide by 4, 8, 32 and 128. A conversion lasts its converter-cycle count times this period, counted from the start edge.
- R4: The first conversion started while enabled after a disabled period lasts 25 converter cycles. This includes a write that sets enable and start together. Every later conversion lasts 13 converter cycles.
- R5: Writing 1 to the start bit (bit 6) with enable set begins a conversion. Bit 6 then reads 1 until the conversion completes. Writing 0 to bit 6 has no effect on a running conversion.
- R6: A start write or a trigger edge that arrives while a conversion is running is ignored, and the running conversion's end time is unchanged.
- R7: Writing enable=0 aborts a running conversion at once. No completion flag is set and the result output keeps its old value.
- R8: With auto-trigger and enable set, a rising edge on the trigger input starts a conversion. A trigger held high does not start another one. Trigger edges are ignored when auto-trigger is off or the converter is disabled.
- R9: With free-running selected and auto-trigger set, a completed conversion immediately starts the next 13-cycle conversion. Clearing auto-trigger lets the running conversion finish and then stops.
- R10: The result word is sampled from the result input at the final converter-clock edge of a conversion. The result output and the completion flag (bit 4) update on that same system-clock edge.
- R11: Writing 1 to bit 4 clears the completion flag. Writing 0 to bit 4 leaves it unchanged.
- R12: A one-cycle pulse on the interrupt-acknowledge input clears the completion flag.
- R13: The interrupt request is high exactly when the completion flag and the interrupt-enable bit (bit 3) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the control word |
| busWrData | input | 8 | Write data for the control word |
| busRdData | output | 8 | Current control word, with the busy state in bit 6 |
| trigIn | input | 1 | Auto-trigger input, rising-edge sensitive |
| freeRunSel | input | 1 | Selects free-running instead of edge triggering when auto-trigger is on |
| irqAck | input | 1 | Interrupt acknowledge; clears the completion flag |
| resultIn | input | RES_W | Conversion result from the analog stub |
| resultOut | output | RES_W | Latched result of the last completed conversion |
| irqReq | output | 1 | Conversion-complete interrupt request |

## Verification
The bound checker watches several rules on every cycle. A disabling write must drop the busy bit on the next cycle. Busy never shows while the converter is disabled. The result output never moves unless the completion flag is set with it. The flag survives any cycle that holds neither a clearing write nor an acknowledge. The interrupt request always equals the flag ANDed with the enable. Conversion lengths cannot be checked by a property, so the bench's scenarios measure them: the 25/13 cycle counts, each prescaler division, the ignored mid-conversion starts and trigger edges, and the free-running chain and its stop. A scoreboard compares each completion's cycle and captured word against times predicted from the start edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Control word bit positions; software decodes these, so they are fixed.
  localparam int BitEn    = 7;
  localparam int BitStart = 6;
  localparam int BitAuto  = 5;
  localparam int BitFlag  = 4;
  localparam int BitIe    = 3;
  localparam int PsHi     = 2;
  localparam int PsW      = 3;

  // Strobes issued by the sequencer to the datapath in one cycle.
  typedef struct packed {
    logic prescClr;  // restart the converter-clock divider
    logic cntLoad;   // load the conversion length counter
    logic cntLong;   // with cntLoad: use the initialisation length
    logic capture;   // latch the result word
  } seqStrobe_t;

  // Divider exponent for a prescaler code: code 0 behaves like code 1.
  function automatic logic [PsW-1:0] divShift(input logic [PsW-1:0] code);
    return (code == '0) ? PsW'(1) : code;
  endfunction

endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int NORM_CYC = 13,
  parameter int INIT_CYC = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [PsW-1:0]   prescSel,
  input  logic [RES_W-1:0] resultIn,
  output logic             lastTick,
  output logic [RES_W-1:0] resultOut
);

  localparam int MaxShift = (1 << PsW) - 1;
  localparam int PrescW   = MaxShift;
  localparam int LongCyc  = (INIT_CYC > NORM_CYC) ? INIT_CYC : NORM_CYC;
  localparam int CntW     = $clog2(LongCyc + 1);

  logic [PrescW-1:0] prescCnt;
  logic [PrescW-1:0] prescLimit;
  logic [PrescW:0]   prescSpan;
  logic              prescTick;
  logic [CntW-1:0]   cycCnt;

  // Terminal count of the divider: 2^shift - 1.
  always_comb begin
    prescSpan  = (PrescW + 1)'(1) << divShift(prescSel);
    prescLimit = PrescW'(prescSpan - (PrescW + 1)'(1));
  end

  assign prescTick = (prescCnt == prescLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (strobe.prescClr || prescTick) begin
      prescCnt <= '0;
    end else begin
      prescCnt <= prescCnt + PrescW'(1);
    end
  end

  // Converter-cycle down counter; a load always wins over a tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (strobe.cntLoad) begin
      cycCnt <= strobe.cntLong ? CntW'(INIT_CYC) : CntW'(NORM_CYC);
    end else if (prescTick && (cycCnt != '0)) begin
      cycCnt <= cycCnt - CntW'(1);
    end
  end

  assign lastTick = prescTick && (cycCnt == CntW'(1));

  // Result register, one flop per bit.
  for (genvar b = 0; b < RES_W; b++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resultOut[b] <= 1'b0;
      end else if (strobe.capture) begin
        resultOut[b] <= resultIn[b];
      end
    end
  end

endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           busWrEn,
  input  logic [7:0]     busWrData,
  input  logic           trigIn,
  input  logic           freeRunSel,
  input  logic           irqAck,
  input  logic           lastTick,
  output seqStrobe_t     strobe,
  output logic [PsW-1:0] prescSel,
  output logic [7:0]     ctrlWord,
  output logic           irqReq
);

  logic enReg, autoReg, ieReg, flagReg, busyReg, firstPend, trigPrev;
  logic enNext, autoNext;
  logic trigRise, startWr, startTrg, startEvt, doneEvt, restartEvt, flagClr;

  // Effective configuration after this cycle's write.
  assign enNext   = busWrEn ? busWrData[BitEn]   : enReg;
  assign autoNext = busWrEn ? busWrData[BitAuto] : autoReg;

  assign trigRise   = trigIn && !trigPrev;
  assign startWr    = busWrEn && busWrData[BitStart];
  assign startTrg   = autoReg && !freeRunSel && trigRise;
  assign startEvt   = enNext && !busyReg && (startWr || startTrg);
  assign doneEvt    = enNext && busyReg && lastTick;
  assign restartEvt = doneEvt && autoNext && freeRunSel;
  assign flagClr    = (busWrEn && busWrData[BitFlag]) || irqAck;

  always_comb begin
    strobe.cntLoad  = startEvt || restartEvt;
    strobe.cntLong  = startEvt && firstPend;
    strobe.prescClr = !enNext || strobe.cntLoad;
    strobe.capture  = doneEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      autoReg  <= 1'b0;
      ieReg    <= 1'b0;
      prescSel <= '0;
    end else if (busWrEn) begin
      enReg    <= busWrData[BitEn];
      autoReg  <= busWrData[BitAuto];
      ieReg    <= busWrData[BitIe];
      prescSel <= busWrData[PsHi -: PsW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= trigIn;
    end
  end

  // Busy: abort on disable, set on start, hold through free-running restarts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg <= 1'b0;
    end else if (!enNext) begin
      busyReg <= 1'b0;
    end else if (startEvt) begin
      busyReg <= 1'b1;
    end else if (doneEvt) begin
      busyReg <= restartEvt;
    end
  end

  // Initialisation pending while disabled, consumed by the first start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstPend <= 1'b1;
    end else if (!enNext) begin
      firstPend <= 1'b1;
    end else if (startEvt) begin
      firstPend <= 1'b0;
    end
  end

  // Completion flag: a completion in the same cycle wins over a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= 1'b0;
    end else if (doneEvt) begin
      flagReg <= 1'b1;
    end else if (flagClr) begin
      flagReg <= 1'b0;
    end
  end

  assign ctrlWord = {enReg, busyReg, autoReg, flagReg, ieReg, prescSel};
  assign irqReq   = flagReg && ieReg;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int NORM_CYC = 13,
  parameter int INIT_CYC = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  logic             trigIn,
  input  logic             freeRunSel,
  input  logic             irqAck,
  input  logic [RES_W-1:0] resultIn,
  output logic [RES_W-1:0] resultOut,
  output logic             irqReq
);

  seqStrobe_t     strobe;
  logic [PsW-1:0] prescSel;
  logic           lastTick;

  adc_seq_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .trigIn     (trigIn),
    .freeRunSel (freeRunSel),
    .irqAck     (irqAck),
    .lastTick   (lastTick),
    .strobe     (strobe),
    .prescSel   (prescSel),
    .ctrlWord   (busRdData),
    .irqReq     (irqReq)
  );

  adc_seq_datapath #(
    .RES_W    (RES_W),
    .NORM_CYC (NORM_CYC),
    .INIT_CYC (INIT_CYC)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .prescSel  (prescSel),
    .resultIn  (resultIn),
    .lastTick  (lastTick),
    .resultOut (resultOut)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic [7:0]       busWrData,
  input logic             irqAck,
  input logic [7:0]       busRdData,
  input logic [RES_W-1:0] resultOut,
  input logic             irqReq
);

  a_r7_disable_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busWrData[7]) |=> !busRdData[6]);

  a_r5_busy_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[6] |-> busRdData[7]);

  a_r10_result_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultOut) |-> busRdData[4]);

  a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[4] && !(busWrEn && busWrData[4]) && !irqAck) |=> busRdData[4]);

  a_r13_irq_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (busRdData[4] && busRdData[3]));

  a_r13_both_give_irq: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[4] && busRdData[3]) |-> irqReq);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .irqAck    (irqAck),
  .busRdData (busRdData),
  .resultOut (resultOut),
  .irqReq    (irqReq)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  localparam int RES_W = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWrEn = 1'b0;
  logic [7:0]       busWrData = '0;
  logic [7:0]       busRdData;
  logic             trigIn = 1'b0;
  logic             freeRunSel = 1'b0;
  logic             irqAck = 1'b0;
  logic [RES_W-1:0] resultIn = '0;
  logic [RES_W-1:0] resultOut;
  logic             irqReq;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.RES_W(RES_W)) i_adc_seq_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .trigIn(trigIn), .freeRunSel(freeRunSel),
    .irqAck(irqAck), .resultIn(resultIn), .resultOut(resultOut), .irqReq(irqReq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    val;
    int    at;
    string tag;
  } expItem_t;
  expItem_t sbQ[$];

  int nChk = 0;
  int nBad = 0;
  bit flagPrev = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int val, input int at, input string tag);
    expItem_t it;
    it.val = val;
    it.at  = at;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // Returns at the falling edge after the write edge; cyc counts that edge.
  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1;
    busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic waitFlag();
    while (!busRdData[4]) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: each rising completion flag pops one expected item.
  always @(negedge clk) begin
    if (rstN) begin
      if (busRdData[4] && !flagPrev) begin
        if (sbQ.size() == 0) begin
          chk(1'b0, "R7/R8 unexpected completion", cyc, -1);
        end else begin
          expItem_t it;
          it = sbQ.pop_front();
          chk(resultOut == RES_W'(it.val), {it.tag, " R10 result"}, int'(resultOut), it.val);
          chk(cyc == it.at, {it.tag, " completion cycle"}, cyc, it.at);
        end
      end
      flagPrev = busRdData[4];
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    int c0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk(busRdData == 8'h00, "R1 control word", busRdData, 0);
    chk(irqReq == 1'b0, "R1 irq", irqReq, 0);
    chk(resultOut == '0, "R1 result", int'(resultOut), 0);

    // Register readback, first conversion at divide-by-8.
    wr(8'h8B);
    chk(busRdData == 8'h8B, "R2 readback", busRdData, 8'h8B);
    wr(8'hCB);
    push(10'h2A3, cyc + 25 * 8, "R4 first");
    chk(busRdData[6] == 1'b1, "R5 busy set", busRdData[6], 1);
    idle(20);
    wr(8'h8B);
    chk(busRdData[6] == 1'b1, "R5 write 0 no effect", busRdData[6], 1);
    wr(8'hCB);   // R6: start while busy must not move the end time
    resultIn = 10'h2A3;  // R10: value changed mid-conversion is what is captured
    waitFlag();
    chk(irqReq == 1'b1, "R13 irq with ie", irqReq, 1);
    chk(busRdData[6] == 1'b0, "R5 busy cleared", busRdData[6], 0);
    wr(8'h8B);
    chk(busRdData[4] == 1'b1, "R11 write 0 keeps flag", busRdData[4], 1);
    wr(8'h9B);
    chk(busRdData[4] == 1'b0, "R11 write 1 clears", busRdData[4], 0);
    chk(irqReq == 1'b0, "R13 irq low after clear", irqReq, 0);

    // Normal length, interrupt disabled, acknowledge clears.
    wr(8'h83);
    resultIn = 10'h0F0;
    wr(8'hC3);
    push(10'h0F0, cyc + 13 * 8, "R4 normal");
    waitFlag();
    chk(irqReq == 1'b0, "R13 irq masked", irqReq, 0);
    @(negedge clk) irqAck = 1'b1;
    @(negedge clk) irqAck = 1'b0;
    chk(busRdData[4] == 1'b0, "R12 ack clears", busRdData[4], 0);

    // Prescaler codes.
    for (int i = 0; i < 5; i++) begin
      logic [2:0] code;
      int sh;
      code = (i == 0) ? 3'd0 : (i == 1) ? 3'd1 : (i == 2) ? 3'd2 : (i == 3) ? 3'd5 : 3'd7;
      sh = (code == 3'd0) ? 1 : int'(code);
      wr(8'h80 | {5'd0, code});
      resultIn = RES_W'(10'h100 + i);
      wr(8'hC0 | {5'd0, code});
      push(10'h100 + i, cyc + 13 * (1 << sh), "R3 prescaler");
      waitFlag();
      wr(8'h90 | {5'd0, code});
    end

    // Enable and start in the same write.
    wr(8'h00);
    chk(busRdData == 8'h00, "R2 disabled word", busRdData, 0);
    resultIn = 10'h3FF;
    wr(8'hC9);
    push(10'h3FF, cyc + 25 * 2, "R4 enable+start");
    waitFlag();
    wr(8'h99);

    // Abort by disabling.
    wr(8'hC9);
    idle(10);
    resultIn = 10'h001;
    wr(8'h09);
    chk(busRdData[6] == 1'b0, "R7 busy dropped", busRdData[6], 0);
    idle(60);
    chk(busRdData[4] == 1'b0, "R7 no flag", busRdData[4], 0);
    chk(resultOut == 10'h3FF, "R7 result kept", int'(resultOut), 10'h3FF);
    wr(8'h89);
    wr(8'hC9);
    push(10'h001, cyc + 25 * 2, "R4 after re-enable");
    waitFlag();
    wr(8'h99);

    // Auto trigger.
    wr(8'hA9);
    resultIn = 10'h0AA;
    @(negedge clk) trigIn = 1'b1;
    @(negedge clk);
    push(10'h0AA, cyc + 13 * 2, "R8 trigger edge");
    idle(8);
    trigIn = 1'b0;
    @(negedge clk) trigIn = 1'b1;   // R6: edge while busy ignored
    waitFlag();
    idle(40);
    chk(busRdData[6] == 1'b0, "R8 held level no restart", busRdData[6], 0);
    wr(8'hB9);
    trigIn = 1'b0;
    wr(8'h89);
    @(negedge clk) trigIn = 1'b1;
    idle(2);
    chk(busRdData[6] == 1'b0, "R8 auto off ignores edge", busRdData[6], 0);
    trigIn = 1'b0;
    wr(8'h29);
    @(negedge clk) trigIn = 1'b1;
    idle(2);
    chk(busRdData[6] == 1'b0, "R8 disabled ignores edge", busRdData[6], 0);
    trigIn = 1'b0;

    // Free running.
    freeRunSel = 1'b1;
    wr(8'hA9);
    resultIn = 10'h111;
    wr(8'hE9);
    c0 = cyc;
    push(10'h111, c0 + 50, "R9 free-run 1");
    push(10'h222, c0 + 76, "R9 free-run 2");
    push(10'h333, c0 + 102, "R9 free-run 3");
    waitFlag();
    resultIn = 10'h222;
    wr(8'hB9);
    chk(busRdData[6] == 1'b1, "R9 restarted", busRdData[6], 1);
    waitFlag();
    resultIn = 10'h333;
    wr(8'h99);
    waitFlag();
    idle(30);
    chk(busRdData[6] == 1'b0, "R9 stopped", busRdData[6], 0);
    wr(8'h99);
    freeRunSel = 1'b0;
    idle(5);

    chk(sbQ.size() == 0, "R10 all completions seen", sbQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule